// File: doc/BRIEF.md
# Serial Converter Result Receiver

This block is the host side of a link to a fast sampling converter that returns each conversion result as an 18-bit serial word on a single data line. On a request, it issues a one-cycle convert strobe and waits a fixed conversion time, counted in system clock cycles. It then sends out a burst of shift clock pulses and deserializes the returned word. The word is presented on a parallel output together with a one-cycle valid pulse.

A static mode input selects one of two capture schemes. With no returned clock, the receiver samples the data line at the end of each high phase of its own shift clock. It finds the word by locking onto a low bit followed by a high bit, checking that the next bit is low, and then taking 18 bits. With a returned clock, each bit is captured on the rising edge of that returned copy of the shift clock. Either sync failure sets a sticky error flag and drops the word. Requests that arrive while a frame is in progress are counted and otherwise ignored.

Top module: `adc_frame_rx`

## Requirements
- R1: A `convReq` sampled high while the block is idle makes `cnvStrobe` high for exactly the next cycle.
- R2: After `CONV_CYCLES` cycles the block emits shift clock pulses on `sclk`. Each pulse is high for one cycle and low for one cycle. There are 21 pulses when `echoMode`=0 and 18 pulses when `echoMode`=1. `sclk` stays low at all other times.
- R3: With `echoMode`=0, the receiver samples `dataIn` at the end of each `sclk` high phase. It waits for a sampled 0 followed by a sampled 1, then requires the next sample to be 0, then takes the following 18 samples as the result, most significant bit first.
- R4: With `echoMode`=1, the receiver takes one bit of `dataIn` at each rising edge of `echoClkIn`. It takes 18 bits, most significant bit first, with no header.
- R5: `resultValid` is high for exactly one cycle. It rises at the clock edge `CONV_CYCLES + 2*N` after the edge that accepted the request, where N is the pulse count from R2. `result` holds the word at that time.
- R6: With `echoMode`=0, if the bit after the header's 1 is 1, `syncError` is set and no `resultValid` is produced for that frame.
- R7: With `echoMode`=0, if no 0-to-1 transition is found within `HUNT_LIMIT` samples (default 8), or the burst ends before 18 data bits are taken, `syncError` is set and no `resultValid` is produced.
- R8: A `convReq` while a frame is in progress produces no strobe and no extra frame. It increments `overrunCount`, which saturates at all ones.
- R9: After reset, `cnvStrobe`, `sclk`, `resultValid`, `syncError`, `result` and `overrunCount` are all 0.
- R10: `syncError` stays set through later good frames until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| echoMode | input | 1 | Static: 1 when a returned shift clock is present |
| convReq | input | 1 | Conversion request |
| dataIn | input | 1 | Serial data from the converter |
| echoClkIn | input | 1 | Returned copy of the shift clock |
| cnvStrobe | output | 1 | Convert start strobe, rising edge starts a conversion |
| sclk | output | 1 | Gated shift clock to the converter |
| result | output | 18 | Last received conversion word |
| resultValid | output | 1 | One-cycle pulse when `result` is new |
| syncError | output | 1 | Sticky frame synchronisation failure |
| overrunCount | output | 8 | Saturating count of ignored requests |

## Verification
The request is taken at edge t0. The convert strobe is due in the cycle right after t0. The valid pulse is due at edge t0+10+42 when there is no returned clock, and at edge t0+10+36 with one. The bench counts edges from the accepting edge and samples on the falling system clock edge, so each check reads a settled value exactly where it falls due. For broken frames, the bench waits past the longest frame and checks both that no valid pulse appeared and that the error flag is set. For overrun, the bench compares the strobe count and the counter value after the frame ends.

// File: rtl/adc_rx_pkg.sv
`timescale 1ns/1ps
package adc_rx_pkg;
  typedef struct packed {
    logic frameStart;
    logic sampleEn;
    logic frameEnd;
  } rxStrobe_t;

  typedef enum logic [1:0] {C_IDLE, C_WAIT, C_BURST} ctrlState_t;
  typedef enum logic [2:0] {R_IDLE, R_HUNT, R_HDR, R_DATA, R_DROP} rxState_t;
endpackage

// File: rtl/adc_rx_ctrl.sv
`timescale 1ns/1ps
module adc_rx_ctrl
  import adc_rx_pkg::*;
#(
  parameter int RES_BITS    = 18,
  parameter int CONV_CYCLES = 10,
  parameter int OVR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             echoMode,
  input  logic             convReq,
  output logic             cnvStrobe,
  output logic             sclk,
  output rxStrobe_t        strb,
  output logic [OVR_W-1:0] overrunCount
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int PW = $clog2(RES_BITS + 4);
  localparam logic [PW-1:0] LAST_SELF = PW'(RES_BITS + 2);
  localparam logic [PW-1:0] LAST_ECHO = PW'(RES_BITS - 1);

  ctrlState_t       state;
  logic [CW-1:0]    waitCnt;
  logic [PW-1:0]    pulseCnt;
  logic             lastPulse;

  assign lastPulse = (pulseCnt == (echoMode ? LAST_ECHO : LAST_SELF));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= C_IDLE;
      waitCnt      <= '0;
      pulseCnt     <= '0;
      sclk         <= 1'b0;
      cnvStrobe    <= 1'b0;
      overrunCount <= '0;
    end else begin
      cnvStrobe <= 1'b0;
      case (state)
        C_IDLE: if (convReq) begin
          cnvStrobe <= 1'b1;
          waitCnt   <= CW'(CONV_CYCLES - 1);
          state     <= C_WAIT;
        end
        C_WAIT: if (waitCnt == '0) begin
          state    <= C_BURST;
          pulseCnt <= '0;
          sclk     <= 1'b0;
        end else begin
          waitCnt <= waitCnt - 1'b1;
        end
        C_BURST: begin
          sclk <= ~sclk;
          if (sclk) begin
            if (lastPulse) state <= C_IDLE;
            else           pulseCnt <= pulseCnt + 1'b1;
          end
        end
        default: state <= C_IDLE;
      endcase
      if (convReq && state != C_IDLE && overrunCount != '1)
        overrunCount <= overrunCount + 1'b1;
    end
  end

  always_comb begin
    strb.frameStart = (state == C_WAIT) && (waitCnt == '0);
    strb.sampleEn   = (state == C_BURST) && sclk;
    strb.frameEnd   = (state == C_BURST) && sclk && lastPulse;
  end
endmodule

// File: rtl/adc_rx_dpath.sv
`timescale 1ns/1ps
module adc_rx_dpath
  import adc_rx_pkg::*;
#(
  parameter int RES_BITS   = 18,
  parameter int HUNT_LIMIT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                echoMode,
  input  logic                dataIn,
  input  logic                echoClkIn,
  input  rxStrobe_t           strb,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid,
  output logic                syncError
);
  localparam int BW = $clog2(RES_BITS + 1);
  localparam int HW = $clog2(HUNT_LIMIT + 1);

  rxState_t            rxState;
  logic [RES_BITS-1:0] shiftReg;
  logic [BW-1:0]       bitCnt;
  logic [HW-1:0]       huntCnt;
  logic                prevZero;
  logic                echoQ;
  logic                bitTake;
  logic                completing;

  assign bitTake    = echoMode ? (echoClkIn & ~echoQ) : strb.sampleEn;
  assign completing = bitTake && (rxState == R_DATA) && (bitCnt == BW'(RES_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState     <= R_IDLE;
      shiftReg    <= '0;
      bitCnt      <= '0;
      huntCnt     <= '0;
      prevZero    <= 1'b0;
      echoQ       <= 1'b0;
      result      <= '0;
      resultValid <= 1'b0;
      syncError   <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      echoQ       <= echoClkIn;
      if (strb.frameStart) begin
        rxState  <= echoMode ? R_DATA : R_HUNT;
        bitCnt   <= '0;
        huntCnt  <= '0;
        prevZero <= 1'b0;
      end else begin
        case (rxState)
          R_HUNT: if (strb.sampleEn) begin
            if (dataIn && prevZero) begin
              rxState <= R_HDR;
            end else begin
              prevZero <= ~dataIn;
              if (huntCnt == HW'(HUNT_LIMIT - 1)) begin
                syncError <= 1'b1;
                rxState   <= R_DROP;
              end else begin
                huntCnt <= huntCnt + 1'b1;
              end
            end
          end
          R_HDR: if (strb.sampleEn) begin
            if (!dataIn) rxState <= R_DATA;
            else begin
              syncError <= 1'b1;
              rxState   <= R_DROP;
            end
          end
          R_DATA: if (bitTake) begin
            shiftReg <= {shiftReg[RES_BITS-2:0], dataIn};
            bitCnt   <= bitCnt + 1'b1;
            if (completing) begin
              result      <= {shiftReg[RES_BITS-2:0], dataIn};
              resultValid <= 1'b1;
              rxState     <= R_IDLE;
            end
          end
          default: ;
        endcase
        if (strb.frameEnd && !echoMode) begin
          rxState <= R_IDLE;
          if (!completing && (rxState == R_HUNT || rxState == R_HDR || rxState == R_DATA))
            syncError <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_frame_rx.sv
`timescale 1ns/1ps
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int RES_BITS    = 18,
  parameter int CONV_CYCLES = 10,
  parameter int HUNT_LIMIT  = 8,
  parameter int OVR_W       = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                echoMode,
  input  logic                convReq,
  input  logic                dataIn,
  input  logic                echoClkIn,
  output logic                cnvStrobe,
  output logic                sclk,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid,
  output logic                syncError,
  output logic [OVR_W-1:0]    overrunCount
);
  rxStrobe_t strb;

  adc_rx_ctrl #(.RES_BITS(RES_BITS), .CONV_CYCLES(CONV_CYCLES), .OVR_W(OVR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .echoMode(echoMode), .convReq(convReq),
    .cnvStrobe(cnvStrobe), .sclk(sclk), .strb(strb), .overrunCount(overrunCount)
  );

  adc_rx_dpath #(.RES_BITS(RES_BITS), .HUNT_LIMIT(HUNT_LIMIT)) i_dpath (
    .clk(clk), .rstN(rstN), .echoMode(echoMode), .dataIn(dataIn),
    .echoClkIn(echoClkIn), .strb(strb), .result(result),
    .resultValid(resultValid), .syncError(syncError)
  );
endmodule

// File: rtl/adc_rx_checker.sv
`timescale 1ns/1ps
module adc_rx_checker #(
  parameter int RES_BITS = 18,
  parameter int OVR_W    = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             echoMode,
  input logic             cnvStrobe,
  input logic             sclk,
  input logic             resultValid,
  input logic             syncError,
  input logic [OVR_W-1:0] overrunCount
);
  logic       sclkQ;
  logic [7:0] riseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      riseCnt <= '0;
    end else begin
      sclkQ <= sclk;
      if (cnvStrobe)          riseCnt <= '0;
      else if (sclk && !sclkQ) riseCnt <= riseCnt + 1'b1;
    end
  end

  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    cnvStrobe |=> !cnvStrobe);
  a_r2_clock_low_at_strobe: assert property (@(posedge clk) disable iff (!rstN)
    cnvStrobe |-> !sclk);
  a_r2_high_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    sclk |=> !sclk);
  a_r5_pulse_count: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> riseCnt == (echoMode ? 8'(RES_BITS) : 8'(RES_BITS + 3)));
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  a_r8_overrun_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(overrunCount) |-> overrunCount == $past(overrunCount) + 1'b1);
  a_r10_sticky_error: assert property (@(posedge clk) disable iff (!rstN)
    syncError |=> syncError);
endmodule

bind adc_frame_rx adc_rx_checker #(.RES_BITS(RES_BITS), .OVR_W(OVR_W)) i_chk (
  .clk(clk), .rstN(rstN), .echoMode(echoMode), .cnvStrobe(cnvStrobe),
  .sclk(sclk), .resultValid(resultValid), .syncError(syncError),
  .overrunCount(overrunCount)
);

// File: tb/test_adc_frame_rx.sv
`timescale 1ns/1ps
module test_adc_frame_rx;
  localparam int CONV = 10;
  localparam int NVEC = 6;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 18'h3FFFF}, {1'b0, 18'h00000}, {1'b0, 18'h2A5A5},
    {1'b1, 18'h15A5A}, {1'b1, 18'h20001}, {1'b0, 18'h1FFFE}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic echoMode = 1'b0;
  logic convReq = 1'b0;
  logic dataIn = 1'b0;
  logic echoClkIn;
  logic cnvStrobe, sclk, resultValid, syncError;
  logic [17:0] result;
  logic [7:0] overrunCount;

  int checks = 0;
  int failures = 0;
  logic seqBits [0:31];
  int seqLen = 0;
  int seqIdx = 0;
  int sclkPulses = 0;
  int strobes = 0;

  always #10 clk = ~clk;
  assign echoClkIn = echoMode ? sclk : 1'b0;

  adc_frame_rx i_adc_frame_rx (
    .clk(clk), .rstN(rstN), .echoMode(echoMode), .convReq(convReq),
    .dataIn(dataIn), .echoClkIn(echoClkIn), .cnvStrobe(cnvStrobe),
    .sclk(sclk), .result(result), .resultValid(resultValid),
    .syncError(syncError), .overrunCount(overrunCount)
  );

  // converter model: present first bit at strobe, advance on each sclk fall
  always @(posedge cnvStrobe or negedge sclk) begin
    if (cnvStrobe) seqIdx = 0;
    else           seqIdx = seqIdx + 1;
    dataIn = (seqIdx < seqLen) ? seqBits[seqIdx] : 1'b0;
  end
  always @(posedge sclk) sclkPulses = sclkPulses + 1;
  always @(posedge clk) if (cnvStrobe) strobes = strobes + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind 0 good, 1 bad header, 2 silent line
  task automatic loadSeq(input bit mode, input int kind, input logic [17:0] data);
    int n = 0;
    if (!mode) begin
      seqBits[0] = 1'b0;
      seqBits[1] = (kind == 2) ? 1'b0 : 1'b1;
      seqBits[2] = (kind == 0) ? 1'b0 : (kind == 1);
      n = 3;
    end
    for (int i = 17; i >= 0; i--) begin
      seqBits[n] = (kind == 2) ? 1'b0 : data[i];
      n++;
    end
    seqLen = n;
  endtask

  task automatic runFrame(input bit mode, input int kind, input logic [17:0] data,
                          input int extraAt, input string tag);
    int cyc = 0;
    int seenAt = -1;
    logic [17:0] got = '0;
    int expLat = CONV + 2 * (mode ? 18 : 21);
    echoMode = mode;
    loadSeq(mode, kind, data);
    sclkPulses = 0;
    strobes = 0;
    @(negedge clk); convReq = 1'b1;
    @(negedge clk); convReq = 1'b0;
    check(cnvStrobe === 1'b1, {tag, " R1 strobe"}, cnvStrobe, 1);
    while (cyc < 90) begin
      @(negedge clk); cyc++;
      convReq = (cyc == extraAt);
      if (resultValid && seenAt < 0) begin seenAt = cyc; got = result; end
    end
    if (kind == 0) begin
      check(seenAt == expLat, {tag, " R5 latency"}, seenAt, expLat);
      check(got == data, {tag, mode ? " R4 data" : " R3 data"}, got, data);
      check(sclkPulses == (mode ? 18 : 21), {tag, " R2 pulses"}, sclkPulses, mode ? 18 : 21);
    end else begin
      check(seenAt < 0, {tag, kind == 1 ? " R6 no valid" : " R7 no valid"}, seenAt, -1);
      check(syncError === 1'b1, {tag, kind == 1 ? " R6 error" : " R7 error"}, syncError, 1);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    // R9 reset state
    check({cnvStrobe, sclk, resultValid, syncError} == 4'b0, "R9 flags", {cnvStrobe, sclk, resultValid, syncError}, 0);
    check(result == 18'h0 && overrunCount == 8'h0, "R9 result/count", {result, overrunCount}, 0);

    for (int v = 0; v < NVEC; v++)
      runFrame(VEC[v][18], 0, VEC[v][17:0], -1, $sformatf("vec%0d", v));
    check(syncError === 1'b0, "R7 no error on good frames", syncError, 0);

    // R8 overrun in both modes
    runFrame(1'b1, 0, 18'h0F0F0, 5, "overrun echo");
    check(strobes == 1, "R8 single strobe", strobes, 1);
    check(overrunCount == 8'd1, "R8 count", overrunCount, 1);
    runFrame(1'b0, 0, 18'h33333, 30, "overrun self");
    check(overrunCount == 8'd2, "R8 count 2", overrunCount, 2);

    // R6 bad header
    runFrame(1'b0, 1, 18'h12345, -1, "badhdr");
    // R10 error sticks across a good frame
    runFrame(1'b0, 0, 18'h0ABCD, -1, "after error");
    check(syncError === 1'b1, "R10 sticky", syncError, 1);

    // R7 silent line
    doReset();
    check(syncError === 1'b0, "R9 error cleared", syncError, 0);
    runFrame(1'b0, 2, 18'h0, -1, "silent");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule